// File: doc/BRIEF.md
# Program Counter and Call Stack Sequencer

This block holds the program counter of a small processor core and keeps return addresses on a stack that grows downward through ordinary data SRAM. Each accepted step either advances the PC by the length of the current instruction (one or two words) or loads a full-width target. A call or interrupt entry loads the target and also saves the return address to SRAM one byte per cycle. A return reads that address back and restores it into the PC.

The stack pointer is a plain register that software can read and write one byte at a time through a small I/O port, so the stack can be placed anywhere in SRAM. While a save or restore sequence runs, a busy output stalls the core, and the unit ignores further steps and I/O writes. Reset is asynchronous and active-low, and its release is synchronised inside the block.

Top module: `flow_ctrl_unit`

## Requirements
- R1: Two clock edges after reset is released, `fetch_addr` is 0, `busy` is 0, and the stack pointer holds all ones (its highest value).
- R2: An accepted step (`step`=1 while `busy`=0) with `ctl_op` 0, or with any unused code 5 to 7, adds 1 to the PC when `len2`=0 and 2 when `len2`=1.
- R3: An accepted step with `ctl_op` 1 (jump) loads `target` into the PC on the next edge and leaves the stack pointer unchanged.
- R4: An accepted step with `ctl_op` 2 (call) loads `target` into the PC. Over the next cycles it writes the return address (old PC plus instruction length) to SRAM, low byte first. Each byte is written at the current stack pointer, and the pointer is then decremented.
- R5: An accepted step with `ctl_op` 4 (interrupt entry) loads the vector from `target` and saves the unmodified current PC as in R4. `len2` has no effect on this.
- R6: An accepted step with `ctl_op` 3 (return) reads SRAM at stack pointer plus one, incrementing the pointer before each byte, high byte first. The PC is loaded from the assembled address on the edge that ends the last read.
- R7: After a call, interrupt entry or return, `busy` stays high for exactly one cycle per return-address byte. Steps presented during that time do not change the PC.
- R8: `io_rdata` shows stack-pointer bits 7:0 when `io_sel`=0, and the bits above 7, zero-extended, when `io_sel`=1.
- R9: A write (`io_wr`=1) while idle replaces the selected stack-pointer byte from the next cycle on. A write while `busy`=1 is dropped.
- R10: With no accepted step and no return completing, the PC holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 1 | Core presents an instruction outcome this cycle |
| ctl_op | input | 3 | Flow operation: 0 next, 1 jump, 2 call, 3 return, 4 interrupt |
| len2 | input | 1 | Current instruction is two words long |
| target | input | PC_W | Jump, call or vector address |
| fetch_addr | output | PC_W | Address of the next instruction to fetch |
| busy | output | 1 | Stack sequence in progress; core must stall |
| mem_addr | output | SP_W | SRAM byte address |
| mem_we | output | 1 | SRAM write strobe |
| mem_re | output | 1 | SRAM read strobe (data returned combinationally) |
| mem_wdata | output | 8 | SRAM write byte |
| mem_rdata | input | 8 | SRAM read byte |
| io_sel | input | 1 | Stack-pointer byte select: 0 low, 1 high |
| io_wr | input | 1 | Stack-pointer byte write strobe |
| io_wdata | input | 8 | Stack-pointer write byte |
| io_rdata | output | 8 | Selected stack-pointer byte |

## Verification
The bench builds the unit with a 16-bit PC, which gives a two-byte save and restore, and a 10-bit stack pointer backed by a 1 KiB SRAM model. The narrow pointer lets the test reach the stack top from reset and relocate the stack with both byte writes. It also checks the zero-extension of the high byte, where only two pointer bits exist above bit 7. The nested call, interrupt and return sequence checks the stack contents in SRAM byte by byte against addresses worked out from the requirements.

// File: rtl/flow_pkg.sv
package flow_pkg;

  typedef enum logic [2:0] {
    OP_SEQ  = 3'd0,
    OP_JMP  = 3'd1,
    OP_CALL = 3'd2,
    OP_RET  = 3'd3,
    OP_IRQ  = 3'd4
  } flow_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_POP  = 2'd2
  } stk_state_e;

endpackage

// File: rtl/pc_seq.sv
module pc_seq
  import flow_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  flow_op_e        op,
  input  logic            len2,
  input  logic [PC_W-1:0] target,
  input  logic            pop_done,
  input  logic [PC_W-1:0] pop_addr,
  output logic [PC_W-1:0] pc,
  output logic [PC_W-1:0] ret_addr,
  output logic            push_req,
  output logic            pop_req
);

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_n;
  logic [PC_W-1:0] pc_inc;
  logic            pc_en;

  always_comb begin
    pc_inc   = pc_q + (len2 ? PC_W'(2) : PC_W'(1));
    ret_addr = (op == OP_IRQ) ? pc_q : pc_inc;
    push_req = accept && ((op == OP_CALL) || (op == OP_IRQ));
    pop_req  = accept && (op == OP_RET);
  end

  always_comb begin
    pc_n  = pc_q;
    pc_en = 1'b0;
    if (pop_done) begin
      pc_n  = pop_addr;
      pc_en = 1'b1;
    end else if (accept) begin
      unique case (op)
        OP_JMP, OP_CALL, OP_IRQ: begin
          pc_n  = target;
          pc_en = 1'b1;
        end
        OP_RET: begin
          pc_en = 1'b0;
        end
        default: begin
          pc_n  = pc_inc;
          pc_en = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (pc_en) begin
      pc_q <= pc_n;
    end
  end

  assign pc = pc_q;

  // R2: a sequential step advances by the instruction length
  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !(op inside {OP_JMP, OP_CALL, OP_IRQ, OP_RET}))
    |=> (pc_q == $past(pc_q) + ($past(len2) ? PC_W'(2) : PC_W'(1))));

  // R3: a jump, call or interrupt takes the target
  p_target_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (op inside {OP_JMP, OP_CALL, OP_IRQ})) |=> (pc_q == $past(target)));

  // R10: without an event the PC holds
  p_pc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !pop_done) |=> (pc_q == $past(pc_q)));

endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import flow_pkg::*;
#(
  parameter int PC_W = 16,
  parameter int SP_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_req,
  input  logic            pop_req,
  input  logic [PC_W-1:0] ret_addr,
  input  logic            sp_wr_lo,
  input  logic            sp_wr_hi,
  input  logic [7:0]      io_wdata,
  input  logic [7:0]      mem_rdata,
  output logic            busy,
  output logic [SP_W-1:0] sp,
  output logic [SP_W-1:0] mem_addr,
  output logic            mem_we,
  output logic            mem_re,
  output logic [7:0]      mem_wdata,
  output logic            pop_done,
  output logic [PC_W-1:0] pop_addr
);

  localparam int NB   = (PC_W + 7) / 8;
  localparam int AW   = NB * 8;
  localparam int CW   = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [SP_W-1:0] SP_TOP = {SP_W{1'b1}};

  stk_state_e      state_q, state_n;
  logic [CW-1:0]   cnt_q, cnt_n;
  logic [SP_W-1:0] sp_q, sp_n;
  logic [AW-1:0]   buf_q, buf_n;
  logic [AW-1:0]   acc_next;
  logic            last;

  always_comb begin
    last      = (cnt_q == CW'(NB - 1));
    mem_we    = (state_q == ST_PUSH);
    mem_re    = (state_q == ST_POP);
    mem_addr  = mem_re ? (sp_q + SP_W'(1)) : sp_q;
    mem_wdata = buf_q[7:0];
    acc_next  = {buf_q[AW-9:0], mem_rdata};
    pop_done  = mem_re && last;
    pop_addr  = acc_next[PC_W-1:0];
    busy      = (state_q != ST_IDLE);
  end

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    sp_n    = sp_q;
    buf_n   = buf_q;
    unique case (state_q)
      ST_IDLE: begin
        if (sp_wr_lo) sp_n[7:0] = io_wdata;
        if (sp_wr_hi) sp_n[SP_W-1:8] = io_wdata[SP_W-9:0];
        if (push_req) begin
          state_n = ST_PUSH;
          cnt_n   = '0;
          buf_n   = AW'(ret_addr);
        end else if (pop_req) begin
          state_n = ST_POP;
          cnt_n   = '0;
        end
      end
      ST_PUSH: begin
        sp_n  = sp_q - SP_W'(1);
        buf_n = buf_q >> 8;
        cnt_n = cnt_q + 1'b1;
        if (last) state_n = ST_IDLE;
      end
      ST_POP: begin
        sp_n  = sp_q + SP_W'(1);
        buf_n = acc_next;
        cnt_n = cnt_q + 1'b1;
        if (last) state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sp_q    <= SP_TOP;
      buf_q   <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      sp_q    <= sp_n;
      buf_q   <= buf_n;
    end
  end

  assign sp = sp_q;

  // Checker state: length of the current busy run
  logic [CW:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else run_q <= '0;
  end

  // R4: every pushed byte moves the pointer down by one
  p_push_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (sp_q == $past(sp_q) - SP_W'(1)));

  // R6: every popped byte moves the pointer up by one
  p_pop_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> (sp_q == $past(sp_q) + SP_W'(1)));

  // R7: a busy run never exceeds one cycle per address byte
  p_busy_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_q < (CW+1)'(NB)));

  // R7: no new sequence is requested while one runs
  p_no_req_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!push_req && !pop_req));

endmodule

// File: rtl/sp_io.sv
module sp_io #(
  parameter int SP_W = 16
) (
  input  logic [SP_W-1:0] sp,
  input  logic            io_sel,
  input  logic            io_wr,
  output logic [7:0]      io_rdata,
  output logic            wr_lo,
  output logic            wr_hi
);

  always_comb begin
    io_rdata = io_sel ? 8'(sp >> 8) : sp[7:0];
    wr_lo    = io_wr && !io_sel;
    wr_hi    = io_wr && io_sel;
  end

endmodule

// File: rtl/flow_ctrl_unit.sv
module flow_ctrl_unit
  import flow_pkg::*;
#(
  parameter int PC_W = 16,
  parameter int SP_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic [2:0]      ctl_op,
  input  logic            len2,
  input  logic [PC_W-1:0] target,
  output logic [PC_W-1:0] fetch_addr,
  output logic            busy,
  output logic [SP_W-1:0] mem_addr,
  output logic            mem_we,
  output logic            mem_re,
  output logic [7:0]      mem_wdata,
  input  logic [7:0]      mem_rdata,
  input  logic            io_sel,
  input  logic            io_wr,
  input  logic [7:0]      io_wdata,
  output logic [7:0]      io_rdata
);

  logic            rs0_q, rs1_q;
  logic            rst_i;
  logic            accept;
  logic            busy_w;
  logic            push_req, pop_req, pop_done;
  logic [PC_W-1:0] ret_addr, pop_addr;
  logic [SP_W-1:0] sp_w;
  logic            wr_lo, wr_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs0_q <= 1'b0;
      rs1_q <= 1'b0;
    end else begin
      rs0_q <= 1'b1;
      rs1_q <= rs0_q;
    end
  end
  assign rst_i = rs1_q;

  assign accept = step && !busy_w;
  assign busy   = busy_w;

  pc_seq #(.PC_W(PC_W)) u_pc (
    .clk      (clk),
    .rst_n    (rst_i),
    .accept   (accept),
    .op       (flow_op_e'(ctl_op)),
    .len2     (len2),
    .target   (target),
    .pop_done (pop_done),
    .pop_addr (pop_addr),
    .pc       (fetch_addr),
    .ret_addr (ret_addr),
    .push_req (push_req),
    .pop_req  (pop_req)
  );

  stack_seq #(.PC_W(PC_W), .SP_W(SP_W)) u_stk (
    .clk       (clk),
    .rst_n     (rst_i),
    .push_req  (push_req),
    .pop_req   (pop_req),
    .ret_addr  (ret_addr),
    .sp_wr_lo  (wr_lo),
    .sp_wr_hi  (wr_hi),
    .io_wdata  (io_wdata),
    .mem_rdata (mem_rdata),
    .busy      (busy_w),
    .sp        (sp_w),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_wdata (mem_wdata),
    .pop_done  (pop_done),
    .pop_addr  (pop_addr)
  );

  sp_io #(.SP_W(SP_W)) u_io (
    .sp       (sp_w),
    .io_sel   (io_sel),
    .io_wr    (io_wr),
    .io_rdata (io_rdata),
    .wr_lo    (wr_lo),
    .wr_hi    (wr_hi)
  );

endmodule

// File: tb/flow_ctrl_unit_test.sv
`timescale 1ns/1ps
module flow_ctrl_unit_test;

  localparam int PC_W = 16;
  localparam int SP_W = 10;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            step;
  logic [2:0]      ctl_op;
  logic            len2;
  logic [PC_W-1:0] target;
  logic [PC_W-1:0] fetch_addr;
  logic            busy;
  logic [SP_W-1:0] mem_addr;
  logic            mem_we, mem_re;
  logic [7:0]      mem_wdata, mem_rdata;
  logic            io_sel, io_wr;
  logic [7:0]      io_wdata, io_rdata;

  logic [7:0] mem [0:(1<<SP_W)-1];
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  flow_ctrl_unit #(.PC_W(PC_W), .SP_W(SP_W)) uut (
    .clk(clk), .rst_n(rst_n), .step(step), .ctl_op(ctl_op), .len2(len2),
    .target(target), .fetch_addr(fetch_addr), .busy(busy),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .io_sel(io_sel), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic read_sp(output logic [15:0] v);
    logic [7:0] lo, hi;
    io_sel = 1'b0; #0.5 lo = io_rdata;
    io_sel = 1'b1; #0.5 hi = io_rdata;
    io_sel = 1'b0;
    v = {hi, lo};
  endtask

  // Presented at a falling edge; returns at the next falling edge.
  task automatic issue(logic [2:0] op, logic l2, logic [PC_W-1:0] tgt);
    step = 1'b1; ctl_op = op; len2 = l2; target = tgt;
    @(negedge clk);
    step = 1'b0; ctl_op = 3'd0; len2 = 1'b0;
  endtask

  task automatic sp_write(logic sel, logic [7:0] d);
    io_sel = sel; io_wr = 1'b1; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0; io_sel = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    check("R1 pc after reset", fetch_addr, 16'h0000);
    check("R1 busy after reset", busy, 1'b0);
    read_sp(v);
    check("R1 R8 sp at top, high byte zero-extended", v, 16'h03FF);
  endtask

  task automatic t_seq;
    issue(3'd0, 1'b0, 16'hFFFF);
    check("R2 one-word step", fetch_addr, 16'h0001);
    issue(3'd0, 1'b1, 16'hFFFF);
    check("R2 two-word step", fetch_addr, 16'h0003);
    @(negedge clk);
    @(negedge clk);
    check("R10 idle holds pc", fetch_addr, 16'h0003);
  endtask

  task automatic t_jump;
    logic [15:0] v;
    issue(3'd1, 1'b1, 16'h1234);
    check("R3 jump loads target", fetch_addr, 16'h1234);
    check("R3 jump not busy", busy, 1'b0);
    read_sp(v);
    check("R3 jump leaves sp", v, 16'h03FF);
  endtask

  task automatic t_call;
    logic [15:0] v;
    issue(3'd2, 1'b1, 16'h2000);
    check("R4 call loads target", fetch_addr, 16'h2000);
    check("R7 busy cycle 1", busy, 1'b1);
    step = 1'b1; ctl_op = 3'd0; len2 = 1'b1;
    @(negedge clk);
    step = 1'b0;
    check("R7 step ignored while busy", fetch_addr, 16'h2000);
    check("R7 busy cycle 2", busy, 1'b1);
    @(negedge clk);
    check("R7 busy drops after two bytes", busy, 1'b0);
    check("R4 low byte at top", mem[10'h3FF], 8'h36);
    check("R4 high byte below", mem[10'h3FE], 8'h12);
    read_sp(v);
    check("R4 sp after call", v, 16'h03FD);
  endtask

  task automatic t_irq;
    logic [15:0] v;
    issue(3'd4, 1'b1, 16'h0040);
    check("R5 vector loaded", fetch_addr, 16'h0040);
    @(negedge clk);
    @(negedge clk);
    check("R5 irq low byte unmodified pc", mem[10'h3FD], 8'h00);
    check("R5 irq high byte", mem[10'h3FC], 8'h20);
    read_sp(v);
    check("R5 sp after irq", v, 16'h03FB);
  endtask

  task automatic t_ret;
    logic [15:0] v;
    issue(3'd3, 1'b0, 16'hFFFF);
    check("R7 busy during return", busy, 1'b1);
    @(negedge clk);
    @(negedge clk);
    check("R6 return from irq", fetch_addr, 16'h2000);
    read_sp(v);
    check("R6 sp after first return", v, 16'h03FD);
    issue(3'd3, 1'b1, 16'hFFFF);
    @(negedge clk);
    @(negedge clk);
    check("R6 return from call", fetch_addr, 16'h1236);
    read_sp(v);
    check("R6 sp back at top", v, 16'h03FF);
  endtask

  task automatic t_sp_io;
    logic [15:0] v;
    sp_write(1'b0, 8'h80);
    read_sp(v);
    check("R9 low byte write", v, 16'h0380);
    sp_write(1'b1, 8'h01);
    read_sp(v);
    check("R9 R8 high byte write", v, 16'h0180);
    issue(3'd2, 1'b0, 16'h0500);
    io_sel = 1'b0; io_wr = 1'b1; io_wdata = 8'h55;
    @(negedge clk);
    io_wr = 1'b0;
    @(negedge clk);
    check("R4 push at relocated sp low", mem[10'h180], 8'h37);
    check("R4 push at relocated sp high", mem[10'h17F], 8'h12);
    read_sp(v);
    check("R9 write during busy dropped", v, 16'h017E);
    issue(3'd3, 1'b0, 16'h0000);
    @(negedge clk);
    @(negedge clk);
    check("R6 return from relocated stack", fetch_addr, 16'h1237);
    issue(3'd7, 1'b0, 16'h0999);
    check("R2 unused code steps", fetch_addr, 16'h1238);
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < (1 << SP_W); i++) mem[i] = 8'h00;
    rst_n = 1'b0; step = 1'b0; ctl_op = 3'd0; len2 = 1'b0; target = '0;
    io_sel = 1'b0; io_wr = 1'b0; io_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_seq();
    t_jump();
    t_call();
    t_irq();
    t_ret();
    t_sp_io();
    done = 1;
    summary();
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
    end
  end

endmodule